// File: doc/BRIEF.md
# Keyed Lai-Massey Round with Selectable Orthomorphism

This block computes one round of a Lai-Massey block cipher on a 64-bit word. The word is split into a left half (upper 32 bits) and a right half (lower 32 bits). The XOR difference of the two halves, together with the full 64-bit round key, is sent out to an external keyed round function. The 32-bit result that comes back is XORed into both halves. The new left half then passes through a one-round Feistel orthomorphism whose inner function is the identity. Encryption rounds use the forward map and decryption rounds use its inverse. The last round of a cipher leaves the orthomorphism out.

The block is purely combinational. A cipher is built by chaining or iterating instances. For encryption, the non-final rounds are run with the encrypt select, followed by one final round. For decryption, the same block is used with the round keys in reverse order, the decrypt select on the non-final rounds, and a final round at the end. The round function stays outside, so one implementation of it can be shared by all three round kinds.

Top module: `lm_round`

## Requirements
- R1: `mix_diff` equals `blk_in[63:32] xor blk_in[31:0]`.
- R2: `mix_key` carries `rkey` unchanged, all 64 bits.
- R3: `blk_out[31:0]` equals `blk_in[31:0] xor mix_res`.
- R4: When `last_rnd` is 1, `blk_out[63:32]` equals `blk_in[63:32] xor mix_res` whatever `dir_dec` is, so no orthomorphism is applied.
- R5: When `last_rnd` is 0 and `dir_dec` is 0 (encrypt), let N = `blk_in[63:32] xor mix_res`, a = N[31:16] and b = N[15:0]. Then `blk_out[63:32]` = {b, a xor b}.
- R6: When `last_rnd` is 0 and `dir_dec` is 1 (decrypt), with a and b defined from N as in R5, `blk_out[63:32]` = {a xor b, a}.
- R7: A final round applied twice with the same key returns the original word.
- R8: An encrypt round with key K1 followed by a final round with key K2 is undone by a decrypt round with K2 followed by a final round with K1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| blk_in | input | 64 | Round input word, left half in the upper 32 bits |
| rkey | input | 64 | Round key |
| dir_dec | input | 1 | 0 selects the forward orthomorphism, 1 selects its inverse |
| last_rnd | input | 1 | 1 bypasses the orthomorphism |
| mix_diff | output | 32 | Difference of the halves, sent to the round function |
| mix_key | output | 64 | Round key, sent to the round function |
| mix_res | input | 32 | Round function result |
| blk_out | output | 64 | Round output word |

## Verification
The hardest property to show from the ports is invertibility (R8). It needs two different round kinds and two keys to cancel through an external function that the block never sees. The bench models a nonlinear keyed function and passes the same instance through four successive settings: encrypt with K1, final with K2, decrypt with K2, final with K1. It does this for a long stream of pseudo-random words and keys. The stream includes words whose halves are equal, which drives a zero difference into the function. It also covers all-ones words and halves that differ in a single bit.

// File: rtl/lm_pkg.sv
package lm_pkg;
   typedef enum logic [1:0] {
      ORTH_FWD  = 2'd0,
      ORTH_INV  = 2'd1,
      ORTH_NONE = 2'd2
   } orth_sel_t;

   function automatic orth_sel_t pick_orth(input logic dec, input logic last);
      if (last) return ORTH_NONE;
      return dec ? ORTH_INV : ORTH_FWD;
   endfunction
endpackage

// File: rtl/lm_mix.sv
module lm_mix #(
   parameter int HALF_W = 32
) (
   input  logic [HALF_W-1:0] left_in,
   input  logic [HALF_W-1:0] right_in,
   input  logic [HALF_W-1:0] f_val,
   output logic [HALF_W-1:0] diff,
   output logic [HALF_W-1:0] left_mix,
   output logic [HALF_W-1:0] right_mix
);
   always_comb begin
      diff      = left_in ^ right_in;
      left_mix  = left_in ^ f_val;
      right_mix = right_in ^ f_val;
   end
endmodule

// File: rtl/lm_orth.sv
module lm_orth #(
   parameter int HALF_W  = 32,
   parameter bit INVERSE = 1'b0
) (
   input  logic [HALF_W-1:0] w_in,
   output logic [HALF_W-1:0] w_out
);
   localparam int QW = HALF_W / 2;

   logic [QW-1:0] hi, lo;
   assign hi = w_in[HALF_W-1:QW];
   assign lo = w_in[QW-1:0];

   generate
      if (INVERSE) begin : g_inv
         assign w_out = {hi ^ lo, hi};
      end else begin : g_fwd
         assign w_out = {lo, hi ^ lo};
      end
   endgenerate
endmodule

// File: rtl/lm_round.sv
module lm_round #(
   parameter int BLK_W = 64,
   parameter int KEY_W = 64
) (
   input  logic [BLK_W-1:0]   blk_in,
   input  logic [KEY_W-1:0]   rkey,
   input  logic               dir_dec,
   input  logic               last_rnd,
   output logic [BLK_W/2-1:0] mix_diff,
   output logic [KEY_W-1:0]   mix_key,
   input  logic [BLK_W/2-1:0] mix_res,
   output logic [BLK_W-1:0]   blk_out
);
   import lm_pkg::*;

   localparam int HALF_W = BLK_W / 2;

   generate
      if (BLK_W % 4 != 0 || BLK_W < 4) begin : g_bad_width
         $error("lm_round: BLK_W must be a positive multiple of 4");
      end
      if (KEY_W < 1) begin : g_bad_key
         $error("lm_round: KEY_W must be positive");
      end
   endgenerate

   logic [HALF_W-1:0] l_mix, r_mix;
   logic [HALF_W-1:0] orth_out [2];
   logic [HALF_W-1:0] l_final;
   orth_sel_t         sel;

   lm_mix #(.HALF_W(HALF_W)) u_mix (
      .left_in  (blk_in[BLK_W-1:HALF_W]),
      .right_in (blk_in[HALF_W-1:0]),
      .f_val    (mix_res),
      .diff     (mix_diff),
      .left_mix (l_mix),
      .right_mix(r_mix)
   );

   genvar gi;
   generate
      for (gi = 0; gi < 2; gi++) begin : g_orth
         lm_orth #(.HALF_W(HALF_W), .INVERSE(gi == 1)) u_orth (
            .w_in (l_mix),
            .w_out(orth_out[gi])
         );
      end
   endgenerate

   assign sel = pick_orth(dir_dec, last_rnd);

   always_comb begin
      unique case (sel)
         ORTH_FWD: l_final = orth_out[0];
         ORTH_INV: l_final = orth_out[1];
         default:  l_final = l_mix;
      endcase
   end

   assign mix_key = rkey;
   assign blk_out = {l_final, r_mix};
endmodule

// File: rtl/lm_round_chk.sv
module lm_round_chk #(
   parameter int BLK_W = 64,
   parameter int KEY_W = 64
) (
   input logic [BLK_W-1:0]   blk_in,
   input logic [KEY_W-1:0]   rkey,
   input logic               dir_dec,
   input logic               last_rnd,
   input logic [BLK_W/2-1:0] mix_diff,
   input logic [KEY_W-1:0]   mix_key,
   input logic [BLK_W/2-1:0] mix_res,
   input logic [BLK_W-1:0]   blk_out
);
   localparam int H = BLK_W / 2;
   localparam int Q = H / 2;

   logic [H-1:0] lo_in, ro_in, lo_out, ro_out;
   assign lo_in  = blk_in[BLK_W-1:H];
   assign ro_in  = blk_in[H-1:0];
   assign lo_out = blk_out[BLK_W-1:H];
   assign ro_out = blk_out[H-1:0];

   always_comb begin
      p_diff_zero_r1: assert ((lo_in == ro_in) == (mix_diff == '0))
         else $error("R1 difference is zero exactly when the halves match");
      p_key_pass_r2: assert (mix_key == rkey)
         else $error("R2 key not passed through");
      p_right_r3: assert ((ro_out ^ ro_in) == mix_res)
         else $error("R3 right half does not absorb the round function");
      if (last_rnd) begin
         p_last_diff_r4: assert ((lo_out ^ ro_out) == (lo_in ^ ro_in))
            else $error("R4 final round changed the half difference");
      end else if (!dir_dec) begin
         p_fwd_r5: assert ((lo_out[H-1:Q] ^ lo_out[Q-1:0]) == (lo_in[H-1:Q] ^ mix_res[H-1:Q]))
            else $error("R5 forward orthomorphism mismatch");
      end else begin
         p_inv_r6: assert (lo_out[Q-1:0] == (lo_in[H-1:Q] ^ mix_res[H-1:Q]))
            else $error("R6 inverse orthomorphism mismatch");
      end
   end
endmodule

bind lm_round lm_round_chk #(.BLK_W(BLK_W), .KEY_W(KEY_W)) u_chk (.*);

// File: tb/lm_round_test.sv
module lm_round_test;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 3000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [63:0] blk_in = '0, rkey = '0, blk_out;
   logic        dir_dec = 1'b0, last_rnd = 1'b0;
   logic [31:0] mix_diff, mix_res;
   logic [63:0] mix_key;

   int checks = 0;
   int failures = 0;
   logic [63:0] seed = 64'h0123_4567_89AB_CDEF;

   function automatic logic [31:0] f_model(input logic [31:0] d, input logic [63:0] k);
      logic [31:0] t;
      t = d ^ k[63:32];
      t = {t[26:0], t[31:27]} + (d ^ k[31:0]) * 32'h9E37_79B1;
      return t ^ {k[15:0], k[47:32]};
   endfunction

   assign mix_res = f_model(mix_diff, mix_key);

   lm_round uut (
      .blk_in(blk_in), .rkey(rkey), .dir_dec(dir_dec), .last_rnd(last_rnd),
      .mix_diff(mix_diff), .mix_key(mix_key), .mix_res(mix_res), .blk_out(blk_out)
   );

   function automatic logic [63:0] next_rand(input logic [63:0] s);
      logic [63:0] x;
      x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      return x;
   endfunction

   function automatic logic [63:0] exp_round(input logic [63:0] x, input logic [63:0] k,
                                             input logic dec, input logic last);
      logic [31:0] f, nl, nr, ol;
      f  = f_model(x[63:32] ^ x[31:0], k);
      nl = x[63:32] ^ f;
      nr = x[31:0] ^ f;
      if (last)      ol = nl;
      else if (!dec) ol = {nl[15:0], nl[31:16] ^ nl[15:0]};
      else           ol = {nl[31:16] ^ nl[15:0], nl[31:16]};
      return {ol, nr};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [63:0] x, input logic [63:0] k, input logic dec,
                        input logic last, output logic [63:0] y);
      @(negedge clk);
      blk_in = x; rkey = k; dir_dec = dec; last_rnd = last;
      #1;
      y = blk_out;
   endtask

   task automatic one_vector(input logic [63:0] x, input logic [63:0] k1, input logic [63:0] k2);
      logic [63:0] y, e1, e2, d1, d2, z1;
      // R1, R2, R3, R5 on an encrypt round
      apply(x, k1, 1'b0, 1'b0, e1);
      chk("R1", {32'h0, mix_diff}, {32'h0, x[63:32] ^ x[31:0]});
      chk("R2", mix_key, k1);
      chk("R3", {32'h0, e1[31:0]}, {32'h0, x[31:0] ^ f_model(x[63:32] ^ x[31:0], k1)});
      chk("R5", e1, exp_round(x, k1, 1'b0, 1'b0));
      // R6 decrypt round on the same input
      apply(x, k1, 1'b1, 1'b0, y);
      chk("R6", y, exp_round(x, k1, 1'b1, 1'b0));
      // R4 final round, both directions
      apply(x, k2, 1'b0, 1'b1, y);
      chk("R4", y, exp_round(x, k2, 1'b0, 1'b1));
      apply(x, k2, 1'b1, 1'b1, z1);
      chk("R4", z1, y);
      // R7 final round is self-inverse
      apply(z1, k2, 1'b1, 1'b1, y);
      chk("R7", y, x);
      // R8 two-round encrypt then decrypt
      apply(e1, k2, 1'b0, 1'b1, e2);
      apply(e2, k2, 1'b1, 1'b0, d1);
      apply(d1, k1, 1'b0, 1'b1, d2);
      chk("R8", d2, x);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 190000);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stim
      logic [63:0] y, x, k1, k2;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      // zero word with zero key gives zero output (R3, R4)
      apply(64'h0, 64'h0, 1'b0, 1'b1, y);
      chk("R4", y, 64'h0);
      apply(64'h0, 64'h0, 1'b0, 1'b0, y);
      chk("R3", y, 64'h0);
      // corner cases
      one_vector(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
      one_vector(64'hDEAD_BEEF_DEAD_BEEF, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
      one_vector(64'h8000_0000_0000_0000, 64'hA5A5_A5A5_5A5A_5A5A, 64'h0F0F_F0F0_0F0F_F0F0);
      one_vector(64'h0000_0001_0000_0000, 64'h0, 64'h0);
      for (int i = 0; i < NVEC; i++) begin
         seed = next_rand(seed); x  = seed;
         seed = next_rand(seed); k1 = seed;
         seed = next_rand(seed); k2 = seed;
         if (i % 16 == 0) x[31:0] = x[63:32];
         one_vector(x, k1, k2);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule